// File: doc/BRIEF.md
# Snooping Write-Through Data Cache Controller

This block is the private data cache of one processor in a shared-memory multiprocessor. It is direct-mapped and holds one data word per line. Every processor store goes to main memory as part of the same operation that refreshes the local copy, so memory never holds older data than the cache. Each store also places a coherence message on a shared broadcast bus, so that the other caches in the system can react to it.

A runtime input selects how stores are announced. In update mode, the message carries both the address and the new word, and peer caches that hold the line overwrite their copy. In invalidate mode, the message carries only the address, and peers drop the line. The block also watches the bus for messages from other nodes and applies them to its own lines. It recognises its own messages by their source number and leaves them alone.

The processor pulses `cpu_req` for one cycle with a word-aligned address and then waits for `cpu_done`. A request made while the controller is busy is not taken.

Top module: `snoop_wt_cache`

## Requirements
- R1: After reset every line is invalid. `cpu_done`, `mem_rd`, `mem_wr`, `bus_req` and `bus_out_valid` are low, and the first read of any address misses.
- R2: A read that hits raises `cpu_done` with the cached word in the cycle after the request, and issues no memory read.
- R3: A read that misses holds `mem_rd` with the address until `mem_ready`. It then fills the line with `mem_rdata` and raises `cpu_done` with that word in the next cycle. A later read of the same address hits.
- R4: A write raises `bus_req` until `bus_grant`. It emits exactly one broadcast in the cycle after the grant. It then holds `mem_wr` with the address and data until `mem_ready`, and raises `cpu_done` in the next cycle. Afterwards the line holds the written word (write-allocate).
- R5: With `mode_inval`=0, a write's broadcast has type 0 (update), the write address, the written data, and source `NODE_ID`.
- R6: With `mode_inval`=1, a write's broadcast has type 1 (invalidate), the write address, data zero, and source `NODE_ID`.
- R7: A snooped type-0 message from another source, whose address matches a valid line's index and tag, replaces that line's word. The next read of that address hits and returns the snooped word.
- R8: A snooped type-1 message from another source, whose address matches a valid line, clears that line. The next read of that address misses and fetches again from memory.
- R9: A snooped message whose tag differs from the line's tag, or whose line is invalid, leaves the cache unchanged.
- R10: A snooped message whose source equals `NODE_ID` leaves the cache unchanged.
- R11: When a snoop and a local read of the same line are sampled in the same cycle, the snoop takes effect first. The read returns the snooped word (type 0) or misses (type 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_inval | input | 1 | 0: update broadcasts, 1: invalidate broadcasts |
| cpu_req | input | 1 | One-cycle access request, taken when idle |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | ADDR_W | Word-aligned byte address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_done |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the current request |
| bus_req | output | 1 | Request to broadcast |
| bus_grant | input | 1 | Broadcast granted |
| bus_out_valid | output | 1 | Outgoing message strobe |
| bus_out_type | output | 1 | 0 update, 1 invalidate |
| bus_out_addr | output | ADDR_W | Outgoing message address |
| bus_out_data | output | DATA_W | Outgoing message data |
| bus_out_src | output | SRC_W | Outgoing source number |
| snp_valid | input | 1 | Incoming message strobe |
| snp_type | input | 1 | 0 update, 1 invalidate |
| snp_addr | input | ADDR_W | Incoming message address |
| snp_data | input | DATA_W | Incoming message data |
| snp_src | input | SRC_W | Incoming source number |

## Verification
Snoop application and a local read lookup can land on the same line in the same clock. The bench provokes this by driving a foreign snoop and a read request at the same falling edge, once with an update and once with an invalidate to the line being read. It judges the result by applying the snoop to its reference model before it computes the read's expectation: a returned word equal to the snooped data for the update case, and a memory refetch, seen on `mem_rd`, for the invalidate case.

// File: rtl/snoop_wt_pkg.sv
// Package: shared encodings for the snooping write-through cache.
package snoop_wt_pkg;
    // Coherence message kind carried on the broadcast bus.
    typedef enum logic {
        MSG_UPDATE = 1'b0,
        MSG_INVAL  = 1'b1
    } msg_kind_t;

    // Controller sequencing states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RFILL  = 2'd1,
        ST_WGRANT = 2'd2,
        ST_WMEM   = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/snoop_match.sv
// Module: snoop_match
// Splits an incoming coherence message address into line index and tag.
// Qualifies the message as foreign: strobed, and from a source other than
// this node. Assumes word-aligned message addresses.
module snoop_match #(
    parameter int ADDR_W  = 32,
    parameter int SRC_W   = 3,
    parameter int OFF_W   = 2,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 26,
    parameter int NODE_ID = 1
) (
    input  logic              snp_valid,
    input  logic [SRC_W-1:0]  snp_src,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_foreign,
    output logic [IDX_W-1:0]  snp_idx,
    output logic [TAG_W-1:0]  snp_tag
);
    // Decode the address fields and filter out this node's own messages.
    always_comb begin
        snp_idx     = snp_addr[OFF_W +: IDX_W];
        snp_tag     = snp_addr[ADDR_W-1 -: TAG_W];
        snp_foreign = snp_valid && (snp_src != SRC_W'(NODE_ID));
    end
endmodule

// File: rtl/line_store.sv
// Module: line_store
// Holds the valid bits, tags and one data word per line of a direct-mapped
// cache. Each cycle it applies a foreign snoop to a matching valid line, then
// any local fill; a fill to the same line overrides the snoop. The lookup
// port reports hit and data as they stand after that cycle's snoop, so a
// same-cycle local access sees the snooped result.
module line_store
    import snoop_wt_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_foreign,
    input  msg_kind_t         snp_kind,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] snp_data,
    input  logic [IDX_W-1:0]  look_idx,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              look_hit,
    output logic [DATA_W-1:0] look_data,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];
    logic [LINES-1:0]  snp_sel;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Snoop affects this line only when index and tag match a valid entry.
        always_comb begin
            snp_sel[g] = snp_foreign && (snp_idx == IDX_W'(g)) &&
                         valid_q[g] && (tag_q[g] == snp_tag);
        end

        // Line state update: snoop first, then local fill wins.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                tag_q[g]   <= '0;
                data_q[g]  <= '0;
            end else begin
                if (snp_sel[g]) begin
                    if (snp_kind == MSG_INVAL) valid_q[g] <= 1'b0;
                    else                       data_q[g]  <= snp_data;
                end
                if (fill_en && (fill_idx == IDX_W'(g))) begin
                    valid_q[g] <= 1'b1;
                    tag_q[g]   <= fill_tag;
                    data_q[g]  <= fill_data;
                end
            end
        end
    end

    logic same_line;

    // Lookup with the same-cycle snoop folded in ahead of the access.
    always_comb begin
        same_line = snp_sel[look_idx];
        look_hit  = valid_q[look_idx] && (tag_q[look_idx] == look_tag) &&
                    !(same_line && (snp_kind == MSG_INVAL));
        look_data = (same_line && (snp_kind == MSG_UPDATE)) ? snp_data
                                                            : data_q[look_idx];
    end
endmodule

// File: rtl/cache_ctrl.sv
// Module: cache_ctrl
// Sequences processor accesses. Read hits complete in one cycle. Read misses
// fetch from memory and fill the line. Writes first win the broadcast bus and
// emit one coherence message in the form picked by the mode input. They then
// write memory and the local line together. Assumes a new request comes only
// while idle; requests seen in other states are not taken.
module cache_ctrl
    import snoop_wt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_inval,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [IDX_W-1:0]  look_idx,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              look_hit,
    input  logic [DATA_W-1:0] look_data,
    output logic              fill_en,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_out_valid,
    output msg_kind_t         bus_out_kind,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data
);
    ctrl_state_t       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              inval_q;

    // Lookup and fill address fields; the lookup uses the live request.
    always_comb begin
        look_idx  = cpu_addr[OFF_W +: IDX_W];
        look_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
        fill_idx  = addr_q[OFF_W +: IDX_W];
        fill_tag  = addr_q[ADDR_W-1 -: TAG_W];
        fill_en   = mem_ready && ((state_q == ST_RFILL) || (state_q == ST_WMEM));
        fill_data = (state_q == ST_RFILL) ? mem_rdata : wdata_q;
    end

    // Memory and bus request levels follow the state directly.
    always_comb begin
        mem_rd    = (state_q == ST_RFILL);
        mem_wr    = (state_q == ST_WMEM);
        bus_req   = (state_q == ST_WGRANT);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Main sequencer: accepts requests, tracks handshakes, drives completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            addr_q        <= '0;
            wdata_q       <= '0;
            inval_q       <= 1'b0;
            cpu_done      <= 1'b0;
            cpu_rdata     <= '0;
            bus_out_valid <= 1'b0;
            bus_out_kind  <= MSG_UPDATE;
            bus_out_addr  <= '0;
            bus_out_data  <= '0;
        end else begin
            cpu_done      <= 1'b0;
            bus_out_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                        inval_q <= mode_inval;
                        if (cpu_we) begin
                            state_q <= ST_WGRANT;
                        end else if (look_hit) begin
                            cpu_done  <= 1'b1;
                            cpu_rdata <= look_data;
                        end else begin
                            state_q <= ST_RFILL;
                        end
                    end
                end
                ST_RFILL: begin
                    if (mem_ready) begin
                        cpu_done  <= 1'b1;
                        cpu_rdata <= mem_rdata;
                        state_q   <= ST_IDLE;
                    end
                end
                ST_WGRANT: begin
                    if (bus_grant) begin
                        bus_out_valid <= 1'b1;
                        bus_out_kind  <= inval_q ? MSG_INVAL : MSG_UPDATE;
                        bus_out_addr  <= addr_q;
                        bus_out_data  <= inval_q ? '0 : wdata_q;
                        state_q       <= ST_WMEM;
                    end
                end
                ST_WMEM: begin
                    if (mem_ready) begin
                        cpu_done <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/snoop_wt_cache.sv
// Module: snoop_wt_cache (top)
// Direct-mapped, one-word-per-line write-through data cache with bus
// snooping. Writes are announced as update or invalidate messages, picked at
// runtime. Foreign messages are applied to matching lines, and this node's
// own messages are recognised by source number and skipped. Assumes a single
// bus grant input and word-aligned addresses.
module snoop_wt_cache
    import snoop_wt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LINES   = 16,
    parameter int SRC_W   = 3,
    parameter int NODE_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_inval,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              bus_out_valid,
    output logic              bus_out_type,
    output logic [ADDR_W-1:0] bus_out_addr,
    output logic [DATA_W-1:0] bus_out_data,
    output logic [SRC_W-1:0]  bus_out_src,
    input  logic              snp_valid,
    input  logic              snp_type,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic [SRC_W-1:0]  snp_src
);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic              snp_foreign;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic              look_hit;
    logic [DATA_W-1:0] look_data;
    logic              fill_en;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;
    msg_kind_t         out_kind;
    msg_kind_t         snp_kind;

    // Map the plain-bit message types onto the package encoding.
    always_comb begin
        snp_kind     = msg_kind_t'(snp_type);
        bus_out_type = out_kind;
        bus_out_src  = SRC_W'(NODE_ID);
    end

    snoop_match #(
        .ADDR_W (ADDR_W), .SRC_W (SRC_W), .OFF_W (OFF_W),
        .IDX_W  (IDX_W),  .TAG_W (TAG_W), .NODE_ID (NODE_ID)
    ) u_match (
        .snp_valid   (snp_valid),
        .snp_src     (snp_src),
        .snp_addr    (snp_addr),
        .snp_foreign (snp_foreign),
        .snp_idx     (snp_idx),
        .snp_tag     (snp_tag)
    );

    line_store #(
        .LINES (LINES), .IDX_W (IDX_W), .TAG_W (TAG_W), .DATA_W (DATA_W)
    ) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_foreign (snp_foreign),
        .snp_kind    (snp_kind),
        .snp_idx     (snp_idx),
        .snp_tag     (snp_tag),
        .snp_data    (snp_data),
        .look_idx    (look_idx),
        .look_tag    (look_tag),
        .look_hit    (look_hit),
        .look_data   (look_data),
        .fill_en     (fill_en),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_data   (fill_data)
    );

    cache_ctrl #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .OFF_W (OFF_W),
        .IDX_W  (IDX_W),  .TAG_W  (TAG_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_inval    (mode_inval),
        .cpu_req       (cpu_req),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_done      (cpu_done),
        .cpu_rdata     (cpu_rdata),
        .look_idx      (look_idx),
        .look_tag      (look_tag),
        .look_hit      (look_hit),
        .look_data     (look_data),
        .fill_en       (fill_en),
        .fill_idx      (fill_idx),
        .fill_tag      (fill_tag),
        .fill_data     (fill_data),
        .mem_rd        (mem_rd),
        .mem_wr        (mem_wr),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready),
        .bus_req       (bus_req),
        .bus_grant     (bus_grant),
        .bus_out_valid (bus_out_valid),
        .bus_out_kind  (out_kind),
        .bus_out_addr  (bus_out_addr),
        .bus_out_data  (bus_out_data)
    );
endmodule

// File: rtl/snoop_wt_cache_chk.sv
// Module: snoop_wt_cache_chk
// Port-level temporal checks for snoop_wt_cache, attached with bind.
module snoop_wt_cache_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SRC_W   = 3,
    parameter int NODE_ID = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              bus_out_valid,
    input logic              bus_out_type,
    input logic [DATA_W-1:0] bus_out_data,
    input logic [SRC_W-1:0]  bus_out_src
);
    // R2: a completion is never reported while memory is still busy.
    p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> (!mem_rd && !mem_wr));

    // R3: the miss address holds steady while memory is not ready.
    p_rd_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> $stable(mem_addr));

    // R3: a finished fill completes the read on the next cycle.
    p_fill_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> cpu_done);

    // R4: memory read and write requests never overlap.
    p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4: the bus request stays up until granted.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);

    // R4: a broadcast follows a granted request and lasts one cycle.
    p_bcast_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_out_valid) |-> $past(bus_req && bus_grant));
    p_bcast_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |=> !bus_out_valid);

    // R4: a finished memory write completes the store on the next cycle.
    p_wr_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready) |=> cpu_done);

    // R5: outgoing messages carry this node's source number.
    p_src_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_out_valid |-> (bus_out_src == SRC_W'(NODE_ID)));

    // R6: invalidate messages carry no data.
    p_inval_nodata_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out_valid && bus_out_type) |-> (bus_out_data == '0));
endmodule

bind snoop_wt_cache snoop_wt_cache_chk #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SRC_W (SRC_W), .NODE_ID (NODE_ID)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_done      (cpu_done),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .mem_ready     (mem_ready),
    .bus_req       (bus_req),
    .bus_grant     (bus_grant),
    .bus_out_valid (bus_out_valid),
    .bus_out_type  (bus_out_type),
    .bus_out_data  (bus_out_data),
    .bus_out_src   (bus_out_src)
);

// File: tb/test_snoop_wt_cache.sv
module test_snoop_wt_cache;
    localparam int CLK_PERIOD = 10;
    localparam int NODE       = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_inval = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        bus_req;
    logic        bus_grant = 1'b0;
    logic        bus_out_valid, bus_out_type;
    logic [31:0] bus_out_addr, bus_out_data;
    logic [2:0]  bus_out_src;
    logic        snp_valid = 1'b0, snp_type = 1'b0;
    logic [31:0] snp_addr = '0, snp_data = '0;
    logic [2:0]  snp_src = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snoop_wt_cache #(.NODE_ID(NODE)) i_snoop_wt_cache (.*);

    int n_cmp = 0, n_bad = 0;
    int rd_count = 0, wr_count = 0, bc_count = 0;
    logic [31:0] last_wr_addr, last_wr_data;
    logic        last_bc_type;
    logic [31:0] last_bc_addr, last_bc_data;
    logic [2:0]  last_bc_src;
    int mwait = 0, gwait = 0, cycles = 0;

    logic [31:0] bmem [256];
    logic        ref_v [16];
    logic [25:0] ref_t [16];
    logic [31:0] ref_d [16];

    function automatic logic [31:0] mk_addr(input logic [3:0] tg, input logic [3:0] ix);
        return {22'd0, tg, ix, 2'b00};
    endfunction

    function automatic logic ref_hit(input logic [31:0] a);
        return ref_v[a[5:2]] && (ref_t[a[5:2]] == a[31:6]);
    endfunction

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Memory model: random wait, then a one-cycle ready.
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready <= 1'b0;
        end else if (rst_n && (mem_rd || mem_wr)) begin
            if (mwait == 0) begin
                mem_ready <= 1'b1;
                if (mem_rd) begin
                    mem_rdata <= bmem[mem_addr[9:2]];
                    rd_count++;
                end else begin
                    bmem[mem_addr[9:2]] = mem_wdata;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                    wr_count++;
                end
                mwait = $urandom % 3;
            end else mwait--;
        end
    end

    // Bus arbiter model and broadcast monitor.
    always @(negedge clk) begin
        if (bus_out_valid) begin
            bc_count++;
            last_bc_type = bus_out_type;
            last_bc_addr = bus_out_addr;
            last_bc_data = bus_out_data;
            last_bc_src  = bus_out_src;
        end
        if (bus_grant) bus_grant <= 1'b0;
        else if (rst_n && bus_req) begin
            if (gwait == 0) begin
                bus_grant <= 1'b1;
                gwait = $urandom % 3;
            end else gwait--;
        end
    end

    // Watchdog: an expired run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_done(input string req, output int lat);
        lat = 0;
        while (!cpu_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        chk(cpu_done, req, "completion", 32'(cpu_done), 32'd1);
    endtask

    // Apply a snoop's effect to the reference cache and the shared memory.
    task automatic ref_snoop(input logic [2:0] src, input logic ty,
                             input logic [31:0] a, input logic [31:0] d);
        if (src != 3'(NODE)) begin
            if (ref_hit(a)) begin
                if (ty) ref_v[a[5:2]] = 1'b0;
                else    ref_d[a[5:2]] = d;
            end
            bmem[a[9:2]] = ty ? $urandom : d;
        end
    endtask

    task automatic snoop(input logic [2:0] src, input logic ty,
                         input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        snp_valid = 1'b1; snp_src = src; snp_type = ty; snp_addr = a; snp_data = d;
        ref_snoop(src, ty, a, d);
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    // Read with optional same-cycle snoop; expectations from the model.
    task automatic do_read(input logic [31:0] a, input string req, input logic sn,
                           input logic [2:0] src, input logic ty, input logic [31:0] sd);
        logic hit; logic [31:0] exp; int rd0; int lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        if (sn) begin
            snp_valid = 1'b1; snp_src = src; snp_type = ty; snp_addr = a; snp_data = sd;
            ref_snoop(src, ty, a, sd);
        end
        hit = ref_hit(a);
        exp = hit ? ref_d[a[5:2]] : bmem[a[9:2]];
        rd0 = rd_count;
        @(negedge clk);
        cpu_req = 1'b0; snp_valid = 1'b0;
        wait_done(req, lat);
        if (hit) begin
            chk(lat == 0, req, "hit latency", 32'(lat), 32'd0);
            chk(rd_count == rd0, req, "no memory read on hit", 32'(rd_count - rd0), 32'd0);
        end else begin
            chk(rd_count == rd0 + 1, req, "memory read on miss", 32'(rd_count - rd0), 32'd1);
            ref_v[a[5:2]] = 1'b1; ref_t[a[5:2]] = a[31:6]; ref_d[a[5:2]] = exp;
        end
        chk(cpu_rdata == exp, req, "read data", cpu_rdata, exp);
    endtask

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input string req);
        int bc0, wr0, lat;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        bc0 = bc_count; wr0 = wr_count;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        wait_done("R4", lat);
        chk(bc_count == bc0 + 1, "R4", "broadcast count", 32'(bc_count - bc0), 32'd1);
        chk(wr_count == wr0 + 1, "R4", "memory write count", 32'(wr_count - wr0), 32'd1);
        chk(last_wr_addr == a && last_wr_data == d, "R4", "memory write data",
            last_wr_data, d);
        chk(last_bc_type == mode_inval, req, "message type", 32'(last_bc_type),
            32'(mode_inval));
        chk(last_bc_addr == a, req, "message address", last_bc_addr, a);
        chk(last_bc_data == (mode_inval ? 32'd0 : d), req, "message data",
            last_bc_data, mode_inval ? 32'd0 : d);
        chk(last_bc_src == 3'(NODE), req, "message source", 32'(last_bc_src), NODE);
        ref_v[a[5:2]] = 1'b1; ref_t[a[5:2]] = a[31:6]; ref_d[a[5:2]] = d;
    endtask

    initial begin
        logic [31:0] a, b, c;
        for (int i = 0; i < 256; i++) bmem[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0107);
        for (int i = 0; i < 16; i++) begin
            ref_v[i] = 1'b0; ref_t[i] = '0; ref_d[i] = '0;
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        chk(!cpu_done && !mem_rd && !mem_wr && !bus_req && !bus_out_valid, "R1",
            "idle outputs", {27'd0, cpu_done, mem_rd, mem_wr, bus_req, bus_out_valid}, 0);

        a = mk_addr(4'd1, 4'd3);
        do_read(a, "R1", 0, 0, 0, 0);      // first read misses (R1, R3)
        do_read(a, "R3", 0, 0, 0, 0);      // R3: refilled line now hits
        do_read(a, "R2", 0, 0, 0, 0);      // R2: hit in one cycle

        b = mk_addr(4'd2, 4'd5);
        mode_inval = 1'b0;
        do_write(b, 32'h1234_5678, "R5");
        do_read(b, "R4", 0, 0, 0, 0);      // R4: write-allocate hit
        mode_inval = 1'b1;
        do_write(b, 32'h9ABC_DEF0, "R6");
        do_read(b, "R4", 0, 0, 0, 0);

        snoop(3'd2, 1'b0, a, 32'hFEED_0001);
        do_read(a, "R7", 0, 0, 0, 0);      // R7: snooped word returned on hit
        snoop(3'd4, 1'b1, a, 32'h0);
        do_read(a, "R8", 0, 0, 0, 0);      // R8: refetch after invalidate
        c = mk_addr(4'd3, 4'd3);           // same index, other tag
        snoop(3'd2, 1'b0, c, 32'hDEAD_0003);
        snoop(3'd5, 1'b1, mk_addr(4'd0, 4'd9), 32'h0);
        do_read(a, "R9", 0, 0, 0, 0);      // R9: unchanged hit
        snoop(3'(NODE), 1'b1, a, 32'h0);
        snoop(3'(NODE), 1'b0, b, 32'h5555_AAAA);
        do_read(a, "R10", 0, 0, 0, 0);     // R10: own invalidate ignored
        do_read(b, "R10", 0, 0, 0, 0);     // R10: own update ignored
        do_read(a, "R11", 1, 3'd6, 1'b0, 32'hABCD_1111);
        do_read(a, "R11", 1, 3'd7, 1'b1, 32'h0);

        // Constrained random mix of reads, writes, snoops and mode changes.
        for (int n = 0; n < 500; n++) begin
            int op;
            logic [31:0] ra;
            op = $urandom % 10;
            ra = mk_addr(4'($urandom % 4), 4'($urandom % 16));
            if (op < 4) begin
                do_read(ra, ref_hit(ra) ? "R2" : "R3", 0, 0, 0, 0);
            end else if (op < 6) begin
                do_write(ra, $urandom, mode_inval ? "R6" : "R5");
            end else if (op < 8) begin
                snoop(3'($urandom % 8), 1'($urandom), ra, $urandom);
            end else if (op < 9) begin
                do_read(ra, "R11", 1, 3'(($urandom % 7) + 2), 1'($urandom), $urandom);
            end else begin
                mode_inval = ~mode_inval;
            end
        end

        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule